// File: doc/BRIEF.md
# AHB Word Access Guard

This block is the slave-side entry point of an accelerator's register and memory window on an AHB-Lite bus. It latches each bus address phase, judges the latched transfer against a fixed access policy during the data phase, and turns transfers that pass into one-cycle word read or write strobes on a simple backend port. Read data comes back from the backend in the same cycle and is returned with an OKAY response and no wait states.

A transfer is refused when any of these holds:
- its protection attribute marks it as an unprivileged access;
- its size is anything other than one 32-bit word;
- its address falls outside the configured window.

A refused transfer never reaches the backend and is answered with a two-cycle ERROR response. IDLE and BUSY transfers, and cycles in which the block is not selected, are answered OKAY at once with no backend activity. The burst type is accepted in every encoding and plays no part in the decision.

Top module: `ahb_guard`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, `hready` is 1, `hresp` is 0 (OKAY), and `be_wr` and `be_rd` are 0.
- R2: An IDLE (`htrans`=0) or BUSY (`htrans`=1) transfer, or a cycle with `hsel`=0, gets `hready`=1 and `hresp`=0 in its data phase, and causes no backend strobe.
- R3: An accepted write (`htrans`=2 NONSEQ or 3 SEQ, `hwrite`=1) asserts `be_wr` for exactly its data-phase cycle. In that cycle `be_addr` equals (address − BASE_ADDR)/4, `be_wdata` equals `hwdata`, `hready`=1 and `hresp`=0. `be_wr` and `be_rd` are never high together.
- R4: An accepted read asserts `be_rd` for its data-phase cycle and returns `be_rdata` on `hrdata` with `hready`=1 and `hresp`=0.
- R5: A NONSEQ/SEQ transfer with `hprot[1]`=0 (unprivileged) is refused with an ERROR response.
- R6: A NONSEQ/SEQ transfer with `hsize` other than 3'b010 (32-bit word) is refused with an ERROR response.
- R7: A NONSEQ/SEQ transfer whose address is below BASE_ADDR, or at or above BASE_ADDR + 4·WIN_WORDS, is refused with an ERROR response.
- R8: The ERROR response takes two cycles. The first has `hready`=0 and `hresp`=1; the second has `hready`=1 and `hresp`=1. `hrdata` is 0 in both. `hresp` is only ever 0 (OKAY) or 1 (ERROR).
- R9: A refused transfer produces neither `be_wr` nor `be_rd`, and so leaves backend contents unchanged.
- R10: The value of `hburst` has no effect on whether a transfer is accepted or on how it is served.
- R11: Asserting `sync_clr` across a clock edge returns all state to the reset state. This includes abandoning an ERROR response in progress, so that the next cycle shows `hready`=1 and `hresp`=0.
- R12: An address phase presented while `hready` is 0 is not captured and leads to no backend access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every other signal is synchronous to it |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously |
| sync_clr | input | 1 | Synchronous reset, active high |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Byte address |
| hwrite | input | 1 | 1 = write, 0 = read |
| hprot | input | 4 | Protection attribute; bit 1 = privileged |
| htrans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hburst | input | 3 | Burst type, accepted in any encoding |
| hsize | input | 3 | Transfer size; only 3'b010 is accepted |
| hwdata | input | 32 | Write data (data phase) |
| hready | output | 1 | Transfer done / slave ready |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| hrdata | output | 32 | Read data |
| be_wr | output | 1 | Backend word write strobe |
| be_rd | output | 1 | Backend word read strobe |
| be_addr | output | IDX_W | Backend word index within the window |
| be_wdata | output | 32 | Backend write data |
| be_rdata | input | 32 | Backend read data, valid in the strobe cycle |

## Verification
The bench builds the block with BASE_ADDR = 32'h0000_1000 and WIN_WORDS = 16. With a window that small, both the last in-window word (offset 15) and the first word past the end (offset 16) can be reached with a short offset field, which exercises the range boundary from both sides. A non-zero base lets the same transfers also confirm the subtraction that produces the backend word index. The bench keeps its own model of the backend contents, so any write that leaks through a refused transfer shows up as a wrong read value later in the run.

// File: rtl/ahb_guard_pkg.sv
package ahb_guard_pkg;

    localparam int          BUS_W       = 32;
    localparam logic [1:0]  TR_IDLE     = 2'd0;
    localparam logic [1:0]  TR_BUSY     = 2'd1;
    localparam logic [1:0]  TR_NSEQ     = 2'd2;
    localparam logic [1:0]  TR_SEQ      = 2'd3;
    localparam logic [2:0]  SZ_WORD     = 3'b010;
    localparam int          PRIV_BIT    = 1;
    localparam logic        RESP_OKAY   = 1'b0;
    localparam logic        RESP_ERROR  = 1'b1;

    // Latched address phase of one transfer
    typedef struct packed {
        logic              valid;
        logic              write;
        logic              priv;
        logic [2:0]        size;
        logic [BUS_W-1:0]  addr;
    } aph_t;

    // Individual policy violations of a latched transfer
    typedef struct packed {
        logic bad_priv;
        logic bad_size;
        logic bad_range;
    } viol_t;

    typedef enum logic {
        ST_PASS     = 1'b0,
        ST_ERR_TAIL = 1'b1
    } rsp_state_e;

    // NONSEQ and SEQ both carry bit 1 set
    function automatic logic is_active(input logic [1:0] trans);
        return trans[1];
    endfunction

    // Unsigned offset compare; wraps below the base to a large value
    function automatic logic in_window(input logic [BUS_W-1:0] addr,
                                       input logic [BUS_W-1:0] base,
                                       input logic [BUS_W-1:0] span);
        logic [BUS_W-1:0] off;
        off = addr - base;
        return off < span;
    endfunction

endpackage

// File: rtl/ahb_guard_capture.sv
module ahb_guard_capture
    import ahb_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              hready_q,
    input  logic              hsel,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic              hpriv,
    input  logic [2:0]        hsize,
    input  logic [BUS_W-1:0]  haddr,
    output aph_t              dp
);

    aph_t nxt;

    always_comb begin
        nxt.valid = hsel && is_active(htrans);
        nxt.write = hwrite;
        nxt.priv  = hpriv;
        nxt.size  = hsize;
        nxt.addr  = haddr;
    end

    // Address phase is sampled only when the bus is ready
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp <= '0;
        end else if (sync_clr) begin
            dp <= '0;
        end else if (hready_q) begin
            dp <= nxt;
        end
    end

endmodule

// File: rtl/ahb_guard_policy.sv
module ahb_guard_policy
    import ahb_guard_pkg::*;
#(
    parameter logic [BUS_W-1:0] BASE_ADDR   = 32'h0000_0000,
    parameter int               WIN_WORDS   = 64,
    parameter bit               RANGE_CHECK = 1'b1,
    localparam int              IDX_W       = $clog2(WIN_WORDS),
    localparam logic [BUS_W-1:0] WIN_BYTES  = BUS_W'(WIN_WORDS * 4)
)(
    input  aph_t              dp,
    output viol_t             viol,
    output logic              reject,
    output logic [IDX_W-1:0]  idx
);

    logic [BUS_W-1:0] offset;

    assign offset        = dp.addr - BASE_ADDR;
    assign idx           = offset[IDX_W+1:2];
    assign viol.bad_priv = !dp.priv;
    assign viol.bad_size = (dp.size != SZ_WORD);

    generate
        if (RANGE_CHECK) begin : g_range
            assign viol.bad_range = !in_window(dp.addr, BASE_ADDR, WIN_BYTES);
        end else begin : g_norange
            assign viol.bad_range = 1'b0;
        end
    endgenerate

    assign reject = dp.valid && (|viol);

    logic unused_policy;
    assign unused_policy = ^{dp.write, offset[1:0], offset[BUS_W-1:IDX_W+2]};

endmodule

// File: rtl/ahb_guard_resp.sv
module ahb_guard_resp
    import ahb_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              dp_valid,
    input  logic              dp_write,
    input  logic              reject,
    input  logic [BUS_W-1:0]  be_rdata,
    output logic              hready,
    output logic              hresp,
    output logic [BUS_W-1:0]  hrdata,
    output logic              be_wr,
    output logic              be_rd
);

    rsp_state_e st, st_nxt;

    always_comb begin
        st_nxt = st;
        hready = 1'b1;
        hresp  = RESP_OKAY;
        hrdata = '0;
        be_wr  = 1'b0;
        be_rd  = 1'b0;
        case (st)
            ST_PASS: begin
                if (dp_valid) begin
                    if (reject) begin
                        hready = 1'b0;
                        hresp  = RESP_ERROR;
                        st_nxt = ST_ERR_TAIL;
                    end else begin
                        be_wr = dp_write;
                        be_rd = !dp_write;
                        if (!dp_write) begin
                            hrdata = be_rdata;
                        end
                    end
                end
            end
            ST_ERR_TAIL: begin
                hresp  = RESP_ERROR;
                st_nxt = ST_PASS;
            end
            default: st_nxt = ST_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_PASS;
        end else if (sync_clr) begin
            st <= ST_PASS;
        end else begin
            st <= st_nxt;
        end
    end

endmodule

// File: rtl/ahb_guard.sv
module ahb_guard
    import ahb_guard_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR   = 32'h0000_0000,
    parameter int          WIN_WORDS   = 64,
    parameter bit          RANGE_CHECK = 1'b1,
    localparam int         IDX_W       = $clog2(WIN_WORDS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              hsel,
    input  logic [31:0]       haddr,
    input  logic              hwrite,
    input  logic [3:0]        hprot,
    input  logic [1:0]        htrans,
    input  logic [2:0]        hburst,
    input  logic [2:0]        hsize,
    input  logic [31:0]       hwdata,
    output logic              hready,
    output logic              hresp,
    output logic [31:0]       hrdata,
    output logic              be_wr,
    output logic              be_rd,
    output logic [IDX_W-1:0]  be_addr,
    output logic [31:0]       be_wdata,
    input  logic [31:0]       be_rdata
);

    aph_t  dp;
    viol_t viol;
    logic  reject;

    ahb_guard_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (sync_clr),
        .hready_q (hready),
        .hsel     (hsel),
        .htrans   (htrans),
        .hwrite   (hwrite),
        .hpriv    (hprot[PRIV_BIT]),
        .hsize    (hsize),
        .haddr    (haddr),
        .dp       (dp)
    );

    ahb_guard_policy #(
        .BASE_ADDR   (BASE_ADDR),
        .WIN_WORDS   (WIN_WORDS),
        .RANGE_CHECK (RANGE_CHECK)
    ) u_policy (
        .dp     (dp),
        .viol   (viol),
        .reject (reject),
        .idx    (be_addr)
    );

    ahb_guard_resp u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (sync_clr),
        .dp_valid (dp.valid),
        .dp_write (dp.write),
        .reject   (reject),
        .be_rdata (be_rdata),
        .hready   (hready),
        .hresp    (hresp),
        .hrdata   (hrdata),
        .be_wr    (be_wr),
        .be_rd    (be_rd)
    );

    assign be_wdata = hwdata;

    // Burst type and the other protection bits do not steer the policy
    logic unused_top;
    assign unused_top = ^{hburst, hprot[3:2], hprot[0], viol};

endmodule

// File: rtl/ahb_guard_chk.sv
module ahb_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sync_clr,
    input logic        hsel,
    input logic [1:0]  htrans,
    input logic        hwrite,
    input logic        hready,
    input logic        hresp,
    input logic [31:0] hrdata,
    input logic        be_wr,
    input logic        be_rd
);

    AST_ERR_FIRST_HAS_ERROR: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        !hready |-> hresp);                                          // R8

    AST_ERR_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        !hready |=> (hready && hresp));                              // R8

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        hresp |-> (hrdata == 32'd0));                                // R8

    AST_NO_STROBE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        hresp |-> (!be_wr && !be_rd));                               // R9

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        !(be_wr && be_rd));                                          // R3

    AST_WR_FROM_ADDR_PHASE: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        be_wr |-> $past(hsel && htrans[1] && hready && hwrite));     // R3

    AST_RD_FROM_ADDR_PHASE: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        be_rd |-> $past(hsel && htrans[1] && hready && !hwrite));    // R4

    AST_NO_CAPTURE_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        !hready |=> (!be_wr && !be_rd));                             // R12

    always_comb begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (hready && !hresp && !be_wr && !be_rd); // R1
        end
    end

endmodule

bind ahb_guard ahb_guard_chk u_chk (.*);

// File: tb/ahb_guard_bench.sv
module ahb_guard_bench;
    import ahb_guard_pkg::*;

    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam int          WIN  = 16;
    localparam int          IW   = $clog2(WIN);

    typedef struct packed {
        logic        wr;
        logic [1:0]  trans;
        logic [2:0]  size;
        logic [3:0]  prot;
        logic [2:0]  burst;
        logic [7:0]  woff;
        logic [31:0] wdata;
        logic        err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 3'b010, 4'b0011, 3'd0, 8'd3,  32'hA5A5_0003, 1'b0}, // R3
        '{1'b0, 2'd2, 3'b010, 4'b0010, 3'd0, 8'd3,  32'h0,         1'b0}, // R4
        '{1'b1, 2'd3, 3'b010, 4'b1010, 3'd3, 8'd15, 32'h1234_5678, 1'b0}, // R3 R10 last word
        '{1'b0, 2'd3, 3'b010, 4'b0110, 3'd7, 8'd15, 32'h0,         1'b0}, // R4 R10
        '{1'b1, 2'd2, 3'b010, 4'b0001, 3'd0, 8'd3,  32'hDEAD_BEEF, 1'b1}, // R5 R9
        '{1'b0, 2'd2, 3'b010, 4'b1101, 3'd1, 8'd3,  32'h0,         1'b1}, // R5
        '{1'b1, 2'd2, 3'b001, 4'b0010, 3'd0, 8'd3,  32'hBAD0_0001, 1'b1}, // R6 R9
        '{1'b0, 2'd3, 3'b011, 4'b0010, 3'd5, 8'd3,  32'h0,         1'b1}, // R6
        '{1'b1, 2'd2, 3'b010, 4'b0010, 3'd0, 8'd16, 32'hBAD0_0002, 1'b1}, // R7 first word past end
        '{1'b0, 2'd2, 3'b010, 4'b0010, 3'd0, 8'd3,  32'h0,         1'b0}, // R9 data unchanged
        '{1'b1, 2'd0, 3'b010, 4'b0010, 3'd0, 8'd3,  32'hBAD0_0003, 1'b0}, // R2 IDLE
        '{1'b1, 2'd1, 3'b010, 4'b0010, 3'd1, 8'd3,  32'hBAD0_0004, 1'b0}, // R2 BUSY
        '{1'b1, 2'd2, 3'b010, 4'b0010, 3'd2, 8'd0,  32'h0F0F_0000, 1'b0}, // R3 R10 WRAP4
        '{1'b0, 2'd3, 3'b010, 4'b0010, 3'd4, 8'd0,  32'h0,         1'b0}  // R4 R10
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_clr = 1'b0;
    logic          hsel = 1'b0;
    logic [31:0]   haddr = '0;
    logic          hwrite = 1'b0;
    logic [3:0]    hprot = 4'b0010;
    logic [1:0]    htrans = TR_IDLE;
    logic [2:0]    hburst = '0;
    logic [2:0]    hsize = SZ_WORD;
    logic [31:0]   hwdata = '0;
    logic          hready, hresp, be_wr, be_rd;
    logic [31:0]   hrdata, be_wdata, be_rdata;
    logic [IW-1:0] be_addr;

    logic [31:0] mem     [WIN];
    logic [31:0] exp_mem [256];
    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    ahb_guard #(.BASE_ADDR(BASE), .WIN_WORDS(WIN)) u_ahb_guard (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .hsel(hsel), .haddr(haddr),
        .hwrite(hwrite), .hprot(hprot), .htrans(htrans), .hburst(hburst), .hsize(hsize),
        .hwdata(hwdata), .hready(hready), .hresp(hresp), .hrdata(hrdata), .be_wr(be_wr),
        .be_rd(be_rd), .be_addr(be_addr), .be_wdata(be_wdata), .be_rdata(be_rdata)
    );

    // Backend word array, single-cycle access
    assign be_rdata = mem[be_addr];
    always @(posedge clk) if (be_wr) mem[be_addr] <= be_wdata;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic go_idle();
        hsel = 1'b0; htrans = TR_IDLE; hwrite = 1'b0;
    endtask

    task automatic addr_phase(input vec_t v);
        hsel = 1'b1; htrans = v.trans; hwrite = v.wr; hsize = v.size;
        hprot = v.prot; hburst = v.burst; haddr = BASE + 32'(v.woff) * 4;
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk); addr_phase(v);
        @(negedge clk); go_idle(); hwdata = v.wdata; #1;
        if (!is_active(v.trans)) begin
            check("R2", "hready", 32'(hready), 32'd1);
            check("R2", "hresp", 32'(hresp), 32'd0);
            check("R2", "strobes", 32'({be_wr, be_rd}), 32'd0);
        end else if (v.err) begin
            check("R8", "err1 hready", 32'(hready), 32'd0);
            check("R8", "err1 hresp", 32'(hresp), 32'd1);
            check("R8", "err1 hrdata", hrdata, 32'd0);
            check("R9", "strobes", 32'({be_wr, be_rd}), 32'd0);
            @(negedge clk); #1;
            check("R8", "err2 hready", 32'(hready), 32'd1);
            check("R8", "err2 hresp", 32'(hresp), 32'd1);
            check("R9", "err2 strobes", 32'({be_wr, be_rd}), 32'd0);
            @(negedge clk); #1;
            check("R8", "after err hresp", 32'(hresp), 32'd0);
        end else if (v.wr) begin
            check("R3", "be_wr", 32'(be_wr), 32'd1);
            check("R3", "be_rd", 32'(be_rd), 32'd0);
            check("R3", "be_addr", 32'(be_addr), 32'(v.woff));
            check("R3", "be_wdata", be_wdata, v.wdata);
            check("R3", "hready/hresp", 32'({hready, hresp}), 32'b10);
            exp_mem[v.woff] = v.wdata;
        end else begin
            check("R4", "be_rd", 32'(be_rd), 32'd1);
            check("R4", "hrdata", hrdata, exp_mem[v.woff]);
            check("R4", "hready/hresp", 32'({hready, hresp}), 32'b10);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < WIN; i++) mem[i] = '0;
        for (int i = 0; i < 256; i++) exp_mem[i] = '0;
        // R1: state held in reset
        repeat (3) @(negedge clk);
        hsel = 1'b1; htrans = TR_NSEQ; hwrite = 1'b1; haddr = BASE;
        #1;
        check("R1", "reset hready", 32'(hready), 32'd1);
        check("R1", "reset hresp", 32'(hresp), 32'd0);
        check("R1", "reset strobes", 32'({be_wr, be_rd}), 32'd0);
        @(negedge clk); go_idle(); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R7: address below the window base
        @(negedge clk);
        hsel = 1'b1; htrans = TR_NSEQ; hwrite = 1'b1; hsize = SZ_WORD;
        hprot = 4'b0010; haddr = BASE - 32'd4;
        @(negedge clk); go_idle(); #1;
        check("R7", "below base hresp", 32'(hresp), 32'd1);
        check("R7", "below base hready", 32'(hready), 32'd0);
        repeat (2) @(negedge clk);

        // R11: sync clear abandons an error in progress
        hsel = 1'b1; htrans = TR_NSEQ; hwrite = 1'b0; hprot = 4'b0000; haddr = BASE;
        @(negedge clk); go_idle(); #1;
        check("R11", "err started", 32'(hready), 32'd0);
        sync_clr = 1'b1;
        @(negedge clk); #1;
        check("R11", "cleared hready", 32'(hready), 32'd1);
        check("R11", "cleared hresp", 32'(hresp), 32'd0);
        sync_clr = 1'b0;
        @(negedge clk); #1;
        check("R11", "stays okay", 32'(hresp), 32'd0);

        // R12: address phase offered during the stalled cycle is dropped
        @(negedge clk);
        hsel = 1'b1; htrans = TR_NSEQ; hwrite = 1'b1; hprot = 4'b0001; haddr = BASE + 32'd20;
        @(negedge clk);
        hprot = 4'b0010; haddr = BASE + 32'd20; hwrite = 1'b1; htrans = TR_NSEQ;
        hwdata = 32'hCAFE_0005; #1;
        check("R12", "stall hready", 32'(hready), 32'd0);
        @(negedge clk); go_idle(); #1;
        check("R12", "tail strobe", 32'(be_wr), 32'd0);
        @(negedge clk); #1;
        check("R12", "no late write", 32'(be_wr), 32'd0);
        run_vec('{1'b0, 2'd2, 3'b010, 4'b0010, 3'd0, 8'd5, 32'h0, 1'b0}); // R12 word 5 still zero

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule